// File: doc/BRIEF.md
# Double-Buffered Output Compare

This block watches an external 16-bit timer count and compares it, on every timer tick, against an active compare value. When the two are equal, the block raises a sticky interrupt flag and drives a single waveform pin according to a 2-bit action code. In the clear-on-match mode it also emits a one-cycle request telling the external counter to restart. The counter itself lives outside the block; the block only sees its value, a tick enable, and TOP/BOTTOM strobes.

Software loads the compare value over an 8-bit bus in two steps. The high byte is written into a staging register, and the low byte write then commits the full 16-bit word in a single cycle. In the two PWM modes the committed word goes into a shadow buffer. That buffer is copied to the active compare value only on the tick that carries the selected update strobe (TOP or BOTTOM), so a pulse is never cut short by a mid-period change. In the normal and clear-on-match modes the word goes straight to the active value. A force strobe fires the pin action without a real match, and a write to the counter suppresses the match of the next tick.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `dbuf_compare`

## Requirements
- R1: After reset, cmp_active, cmp_buffer, pin_out, irq_flag and restart_req are all zero.
- R2: A wr_hi strobe stages bus_data without changing cmp_active or cmp_buffer. A later wr_lo strobe commits {staged byte, bus_data} as one 16-bit word, visible one cycle later.
- R3: In mode 0 (normal) and mode 1 (clear-on-match), a committed word appears in both cmp_active and cmp_buffer one cycle after wr_lo.
- R4: In mode 2 (PWM, update at TOP) and mode 3 (PWM, update at BOTTOM), a committed word changes only cmp_buffer. cmp_active takes the buffer value only after a cycle with tick and at_top high (mode 2) or tick and at_bottom high (mode 3). The other strobe does not load it.
- R5: A match is a cycle with tick high and count equal to cmp_active. A match sets irq_flag one cycle later; a tick with an unequal count does not.
- R6: On a match, action 3 sets pin_out, action 2 clears it, action 1 toggles it, and action 0 leaves it unchanged.
- R7: In modes 0 and 1, a force_cmp strobe applies the action to pin_out one cycle later. It does not set irq_flag and does not raise restart_req.
- R8: In modes 2 and 3, force_cmp has no effect on pin_out.
- R9: A cnt_wr strobe blocks the match of the next tick, even if several cycles without a tick pass in between. The tick after that matches normally.
- R10: irq_flag stays set until a flag_clr strobe. When flag_clr and a match occur in the same cycle, the flag ends up set.
- R11: In mode 1 a match raises restart_req for exactly one cycle, one cycle after the match. In the other modes restart_req stays low.
- R12: With tick low, an equal count produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, one cycle per count step |
| count | input | 16 | Current timer count |
| at_top | input | 1 | Count is at TOP (qualified by tick) |
| at_bottom | input | 1 | Count is at BOTTOM (qualified by tick) |
| mode | input | 2 | 0 normal, 1 clear-on-match, 2 PWM update at TOP, 3 PWM update at BOTTOM |
| action | input | 2 | 0 hold, 1 toggle, 2 clear, 3 set |
| bus_data | input | 8 | Byte written to the compare register |
| wr_hi | input | 1 | Stage high byte |
| wr_lo | input | 1 | Commit low byte together with staged high byte |
| cnt_wr | input | 1 | Software wrote the counter |
| force_cmp | input | 1 | Force a compare action strobe |
| flag_clr | input | 1 | Clear irq_flag strobe |
| cmp_active | output | 16 | Active compare value |
| cmp_buffer | output | 16 | Shadow buffer value |
| pin_out | output | 1 | Waveform output pin |
| irq_flag | output | 1 | Compare interrupt flag |
| restart_req | output | 1 | One-cycle counter restart request |

## Verification
Every result is registered once. A strobe or tick driven in one cycle shows its effect on cmp_active, cmp_buffer, pin_out, irq_flag or restart_req right after the next rising edge. The bench changes inputs on falling edges and samples at the following falling edge, so each check sees exactly one edge of effect. For the buffered and blocked cases, the bench first checks across intervening cycles that nothing has moved yet (buffer not loaded, match still suppressed), and only then looks for the change on the tick that is due.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_CLRMATCH = 2'd1,
    MODE_PWM_TOP  = 2'd2,
    MODE_PWM_BOT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  function automatic logic is_pwm(mode_e m);
    return (m == MODE_PWM_TOP) || (m == MODE_PWM_BOT);
  endfunction
endpackage

// File: rtl/ocmp_store.sv
module ocmp_store
  import ocmp_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode_i,
  input  logic            tick_i,
  input  logic            at_top_i,
  input  logic            at_bottom_i,
  input  logic [BW-1:0]   bus_i,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  output logic [2*BW-1:0] active_o,
  output logic [2*BW-1:0] buffer_o
);
  localparam int W = 2 * BW;

  logic [BW-1:0] stage_q;
  logic [W-1:0]  buf_q;
  logic [W-1:0]  act_q;
  logic [W-1:0]  word;
  logic          pwm;
  logic          load_now;

  assign word = {stage_q, bus_i};
  assign pwm  = is_pwm(mode_i);

  // Update point of the buffered modes
  always_comb begin
    unique case (mode_i)
      MODE_PWM_TOP: load_now = tick_i && at_top_i;
      MODE_PWM_BOT: load_now = tick_i && at_bottom_i;
      default:      load_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      buf_q   <= '0;
      act_q   <= '0;
    end else begin
      if (wr_hi_i) stage_q <= bus_i;
      if (wr_lo_i) buf_q <= word;
      if (!pwm && wr_lo_i)  act_q <= word;
      else if (load_now)    act_q <= buf_q;
    end
  end

  assign active_o = act_q;
  assign buffer_o = buf_q;

  p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load_now) |=> $stable(act_q));

  p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && wr_lo_i) |=> (act_q == $past(word)));

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo_i && !load_now) |=> ($stable(buf_q) && $stable(act_q)));
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] active_i,
  input  logic         cnt_wr_i,
  output logic         match_o
);
  logic block_q;

  // A counter write arms the blocker; the next tick consumes it.
  always_ff @(posedge clk) begin
    if (!rst_n)        block_q <= 1'b0;
    else if (cnt_wr_i) block_q <= 1'b1;
    else if (tick_i)   block_q <= 1'b0;
  end

  assign match_o = tick_i && (count_i == active_i) && !block_q;

  p_block_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> !match_o);

  p_block_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (block_q && !tick_i && !cnt_wr_i) |=> block_q);
endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave
  import ocmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_i,
  input  act_e  act_i,
  input  logic  match_i,
  input  logic  force_i,
  input  logic  flag_clr_i,
  output logic  pin_o,
  output logic  flag_o,
  output logic  restart_o
);
  logic pin_q, flag_q, rst_q;
  logic fire;
  logic pin_d;

  assign fire = match_i || (force_i && !is_pwm(mode_i));

  always_comb begin
    pin_d = pin_q;
    if (fire) begin
      unique case (act_i)
        ACT_SET:    pin_d = 1'b1;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_TOGGLE: pin_d = ~pin_q;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (match_i)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      rst_q <= match_i && (mode_i == MODE_CLRMATCH);
    end
  end

  assign pin_o     = pin_q;
  assign flag_o    = flag_q;
  assign restart_o = rst_q;

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> flag_q);

  p_hold_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_HOLD) |=> $stable(pin_q));

  p_force_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && !match_i && !flag_q) |=> (!flag_q && !rst_q));

  p_pwm_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm(mode_i) && !match_i) |=> $stable(pin_q));

  p_restart_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_CLRMATCH) |=> !rst_q);
endmodule

// File: rtl/dbuf_compare.sv
module dbuf_compare
  import ocmp_pkg::*;
#(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [W-1:0]  count,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic [1:0]    mode,
  input  logic [1:0]    action,
  input  logic [BW-1:0] bus_data,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          cnt_wr,
  input  logic          force_cmp,
  input  logic          flag_clr,
  output logic [W-1:0]  cmp_active,
  output logic [W-1:0]  cmp_buffer,
  output logic          pin_out,
  output logic          irq_flag,
  output logic          restart_req
);
  mode_e      mode_s;
  act_e       act_s;
  logic [W-1:0] active_w;
  logic         match_w;

  assign mode_s = mode_e'(mode);
  assign act_s  = act_e'(action);

  ocmp_store #(.BW(BW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_s),
    .tick_i      (tick),
    .at_top_i    (at_top),
    .at_bottom_i (at_bottom),
    .bus_i       (bus_data),
    .wr_hi_i     (wr_hi),
    .wr_lo_i     (wr_lo),
    .active_o    (active_w),
    .buffer_o    (cmp_buffer)
  );

  ocmp_match #(.W(W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .count_i  (count),
    .active_i (active_w),
    .cnt_wr_i (cnt_wr),
    .match_o  (match_w)
  );

  ocmp_wave u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_s),
    .act_i      (act_s),
    .match_i    (match_w),
    .force_i    (force_cmp),
    .flag_clr_i (flag_clr),
    .pin_o      (pin_out),
    .flag_o     (irq_flag),
    .restart_o  (restart_req)
  );

  assign cmp_active = active_w;

  p_notick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq_flag && !flag_clr) |=> !irq_flag);
endmodule

// File: tb/dbuf_compare_test.sv
module dbuf_compare_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] count = '0;
  logic        at_top = 1'b0, at_bottom = 1'b0;
  logic [1:0]  mode = 2'd0, action = 2'd0;
  logic [7:0]  bus_data = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, cnt_wr = 1'b0;
  logic        force_cmp = 1'b0, flag_clr = 1'b0;
  logic [15:0] cmp_active, cmp_buffer;
  logic        pin_out, irq_flag, restart_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbuf_compare uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .at_top(at_top), .at_bottom(at_bottom), .mode(mode), .action(action),
    .bus_data(bus_data), .wr_hi(wr_hi), .wr_lo(wr_lo), .cnt_wr(cnt_wr),
    .force_cmp(force_cmp), .flag_clr(flag_clr),
    .cmp_active(cmp_active), .cmp_buffer(cmp_buffer),
    .pin_out(pin_out), .irq_flag(irq_flag), .restart_req(restart_req)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic write_cmp(logic [15:0] w);
    cyc(); wr_hi = 1'b1; bus_data = w[15:8];
    cyc(); wr_hi = 1'b0; wr_lo = 1'b1; bus_data = w[7:0];
    cyc(); wr_lo = 1'b0;
  endtask

  task automatic do_tick(logic [15:0] c, logic top, logic bot);
    cyc(); tick = 1'b1; count = c; at_top = top; at_bottom = bot;
    cyc(); tick = 1'b0; at_top = 1'b0; at_bottom = 1'b0;
  endtask

  task automatic clear_flag();
    cyc(); flag_clr = 1'b1;
    cyc(); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", cmp_active, 16'h0);
    check("R1 buffer", cmp_buffer, 16'h0);
    check("R1 pin", {15'b0, pin_out}, 16'h0);
    check("R1 flag", {15'b0, irq_flag}, 16'h0);
    check("R1 restart", {15'b0, restart_req}, 16'h0);
  endtask

  task automatic t_byte_write();
    mode = 2'd0;
    cyc(); wr_hi = 1'b1; bus_data = 8'h12;
    cyc(); wr_hi = 1'b0;
    check("R2 staged only", cmp_active, 16'h0000);
    check("R2 staged only buf", cmp_buffer, 16'h0000);
    wr_lo = 1'b1; bus_data = 8'h34;
    cyc(); wr_lo = 1'b0;
    check("R2/R3 active", cmp_active, 16'h1234);
    check("R3 buffer", cmp_buffer, 16'h1234);
    mode = 2'd1;
    write_cmp(16'h2345);
    check("R3 clrmatch direct", cmp_active, 16'h2345);
    mode = 2'd0;
    write_cmp(16'h1234);
  endtask

  task automatic t_actions();
    mode = 2'd0;
    action = 2'd3;
    do_tick(16'h1233, 1'b0, 1'b0);
    check("R5 no match flag", {15'b0, irq_flag}, 16'h0);
    cyc(); count = 16'h1234;
    cyc();
    check("R12 no tick no flag", {15'b0, irq_flag}, 16'h0);
    do_tick(16'h1234, 1'b0, 1'b0);
    check("R5 match flag", {15'b0, irq_flag}, 16'h1);
    check("R6 set", {15'b0, pin_out}, 16'h1);
    cyc(); cyc();
    check("R10 sticky", {15'b0, irq_flag}, 16'h1);
    clear_flag();
    check("R10 cleared", {15'b0, irq_flag}, 16'h0);
    action = 2'd1;
    do_tick(16'h1234, 1'b0, 1'b0);
    check("R6 toggle low", {15'b0, pin_out}, 16'h0);
    do_tick(16'h1234, 1'b0, 1'b0);
    check("R6 toggle high", {15'b0, pin_out}, 16'h1);
    action = 2'd0;
    clear_flag();
    do_tick(16'h1234, 1'b0, 1'b0);
    check("R6 hold pin", {15'b0, pin_out}, 16'h1);
    check("R5 hold still flags", {15'b0, irq_flag}, 16'h1);
    action = 2'd2;
    do_tick(16'h1234, 1'b0, 1'b0);
    check("R6 clear", {15'b0, pin_out}, 16'h0);
    check("R11 normal no restart", {15'b0, restart_req}, 16'h0);
  endtask

  task automatic t_flag_race();
    clear_flag();
    cyc(); tick = 1'b1; count = 16'h1234; flag_clr = 1'b1;
    cyc(); tick = 1'b0; flag_clr = 1'b0;
    check("R10 set wins", {15'b0, irq_flag}, 16'h1);
    clear_flag();
  endtask

  task automatic t_force();
    mode = 2'd0; action = 2'd3;
    cyc(); force_cmp = 1'b1; count = 16'h0001;
    cyc(); force_cmp = 1'b0;
    check("R7 force sets pin", {15'b0, pin_out}, 16'h1);
    check("R7 force no flag", {15'b0, irq_flag}, 16'h0);
    mode = 2'd1; action = 2'd1;
    cyc(); force_cmp = 1'b1;
    cyc(); force_cmp = 1'b0;
    check("R7 force toggles", {15'b0, pin_out}, 16'h0);
    check("R7 no restart", {15'b0, restart_req}, 16'h0);
    mode = 2'd2;
    cyc(); force_cmp = 1'b1;
    cyc(); force_cmp = 1'b0;
    check("R8 pwm force ignored", {15'b0, pin_out}, 16'h0);
    mode = 2'd3;
    cyc(); force_cmp = 1'b1;
    cyc(); force_cmp = 1'b0;
    check("R8 pwm bot force ignored", {15'b0, pin_out}, 16'h0);
  endtask

  task automatic t_pwm_buffer();
    mode = 2'd2; action = 2'd0;
    write_cmp(16'h00AA);
    check("R4 buffer written", cmp_buffer, 16'h00AA);
    check("R4 active kept", cmp_active, 16'h1234);
    do_tick(16'h0000, 1'b0, 1'b1);
    check("R4 bottom ignored in top mode", cmp_active, 16'h1234);
    do_tick(16'h00FF, 1'b1, 1'b0);
    check("R4 top loads", cmp_active, 16'h00AA);
    mode = 2'd3;
    write_cmp(16'h0055);
    do_tick(16'h00FF, 1'b1, 1'b0);
    check("R4 top ignored in bottom mode", cmp_active, 16'h00AA);
    cyc(); at_bottom = 1'b1;
    cyc(); at_bottom = 1'b0;
    check("R4 strobe needs tick", cmp_active, 16'h00AA);
    do_tick(16'h0000, 1'b0, 1'b1);
    check("R4 bottom loads", cmp_active, 16'h0055);
  endtask

  task automatic t_block();
    mode = 2'd0; action = 2'd3;
    write_cmp(16'h0100);
    clear_flag();
    cyc(); cnt_wr = 1'b1;
    cyc(); cnt_wr = 1'b0;
    cyc(); cyc(); cyc();
    do_tick(16'h0100, 1'b0, 1'b0);
    check("R9 blocked flag", {15'b0, irq_flag}, 16'h0);
    check("R9 blocked pin", {15'b0, pin_out}, 16'h0);
    do_tick(16'h0100, 1'b0, 1'b0);
    check("R9 next tick matches", {15'b0, irq_flag}, 16'h1);
    check("R9 next tick pin", {15'b0, pin_out}, 16'h1);
  endtask

  task automatic t_restart();
    mode = 2'd1; action = 2'd0;
    clear_flag();
    do_tick(16'h0100, 1'b0, 1'b0);
    check("R11 restart pulse", {15'b0, restart_req}, 16'h1);
    cyc();
    check("R11 restart one cycle", {15'b0, restart_req}, 16'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_byte_write();
    t_actions();
    t_flag_race();
    t_force();
    t_pwm_buffer();
    t_block();
    t_restart();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule